// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block sits between a card-side data bus (side A) and a shared backplane bus (side B) and moves a word in each direction over two independent, identical paths. Each path keeps one stored word that can pass input straight through, hold a value caught when its latch enable drops, or load on a rising edge of its own data clock. An active-low clock enable qualifies every load on a path, and an active-low output enable decides whether the path drives its far side at all.

Every control, data and clock input is treated as asynchronous. A free-running core clock samples them through multi-stage synchronizers, and edge detection runs on the sampled values. The three-state A outputs are presented as a data bus plus a drive-enable bit. The wired-OR B outputs are presented as a pull-low mask. The A-to-B clock is also forwarded to the backplane as a pull-low signal, gated by the A-to-B output enable. A clock arriving from the backplane is returned to side A, gated by the B-to-A output enable.

Top module: `dual_path_bus_xcvr`

## Requirements
- R1: After reset both stored words are 0 and every output is released (a_out_en_o = 0, b_pull_low_o = 0, clk_fwd_pull_low_o = 0, clk_ret_en_o = 0) until the relevant output enable is driven LOW; the stored 0 is then presented.
- R2: While a path's latch enable is HIGH, its output follows its input, whatever its clock enable and data clock are doing.
- R3: When the latch enable falls with the clock enable LOW, the input present at the fall is stored, and it is held afterwards while the data clock stays steady.
- R4: With latch enable LOW and clock enable LOW, a LOW-to-HIGH transition of the data clock stores the input. Holding the clock steady HIGH or LOW afterwards changes nothing.
- R5: With clock enable HIGH and latch enable LOW, data-clock edges and input changes leave the presented value unchanged.
- R6: With an output enable HIGH the path's outputs are released. With it LOW they drive the presented value.
- R7: Bit i of b_pull_low_o is 1 exactly when the A-to-B path is enabled and its presented bit i is 0.
- R8: The B-to-A path uses only its own controls, and changes on them leave the A-to-B output unchanged.
- R9: clk_fwd_pull_low_o is 1 exactly when the A-to-B output enable is LOW and the A-to-B clock is LOW. clk_ret_o equals clk_bus_i and clk_ret_en_o is 1 only while the B-to-A output enable is LOW.
- R10: An input change is not visible one core cycle after it is applied, and a clocked load is visible by the third core clock edge (with SYNC_STAGES = 2).
- R11: A latch-enable fall and a data-clock rise seen in the same core cycle, with clock enable LOW, store the input of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running core sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_in_i | input | WIDTH | Word received on side A |
| b_in_i | input | WIDTH | Word received on side B |
| ab_le_i | input | 1 | A-to-B latch enable, transparent when HIGH |
| ab_clken_ni | input | 1 | A-to-B clock enable, active LOW |
| ab_clk_i | input | 1 | A-to-B data clock |
| ab_oe_ni | input | 1 | A-to-B output enable, active LOW |
| ba_le_i | input | 1 | B-to-A latch enable, transparent when HIGH |
| ba_clken_ni | input | 1 | B-to-A clock enable, active LOW |
| ba_clk_i | input | 1 | B-to-A data clock |
| ba_oe_ni | input | 1 | B-to-A output enable, active LOW |
| clk_bus_i | input | 1 | Clock received from the backplane |
| a_out_o | output | WIDTH | Word presented on side A |
| a_out_en_o | output | 1 | Drive enable for a_out_o |
| b_pull_low_o | output | WIDTH | Per-bit pull-low mask for side B |
| clk_fwd_pull_low_o | output | 1 | Pull-low for the forwarded A-to-B clock |
| clk_ret_o | output | 1 | Returned backplane clock on side A |
| clk_ret_en_o | output | 1 | Drive enable for clk_ret_o |

## Verification
The bench builds the block with WIDTH = 17 and SYNC_STAGES = 2. At that width, alternating and irregular patterns reach every bit of the stored words and of the pull-low mask, including the top odd bit. With two sampling stages the latency is short and known, so the bench can check the exact cycle in which a load appears as well as the value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Per-cycle action chosen for a path's stored word.
  typedef enum logic [1:0] {
    PM_PASS = 2'd0,
    PM_HOLD = 2'd1,
    PM_LOAD = 2'd2
  } path_mode_e;

  // Bit positions inside the sampled control bundle of one path.
  localparam int unsigned CB_OE_N  = 0;
  localparam int unsigned CB_CKEN_N = 1;
  localparam int unsigned CB_DCLK  = 2;
  localparam int unsigned CB_LE    = 3;
  localparam int unsigned CB_BITS  = 4;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = async_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic             le_i,
  input  logic             clken_ni,
  input  logic             dclk_i,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             drive_o
);
  logic             le_q, le_d;
  logic             dclk_q, dclk_d;
  logic [WIDTH-1:0] store_q, store_d;
  logic             le_fall, clk_rise;
  path_mode_e       mode;

  // Next-state logic
  always_comb begin
    le_fall  = le_q & ~le_i;
    clk_rise = dclk_i & ~dclk_q;
    le_d     = le_i;
    dclk_d   = dclk_i;

    if (le_i)                                  mode = PM_PASS;
    else if (!clken_ni && (le_fall || clk_rise)) mode = PM_LOAD;
    else                                       mode = PM_HOLD;

    unique case (mode)
      PM_PASS, PM_LOAD: store_d = d_i;
      default:          store_d = store_q;
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q    <= 1'b0;
      dclk_q  <= 1'b0;
      store_q <= '0;
    end else begin
      le_q    <= le_d;
      dclk_q  <= dclk_d;
      store_q <= store_d;
    end
  end

  assign q_o     = le_i ? d_i : store_q;
  assign drive_o = ~oe_ni;

  // R3
  latch_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_q && !le_i && !clken_ni) |=> (le_i || q_o == $past(d_i)));

  // R4
  clk_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !clken_ni && dclk_i && !dclk_q) |=> (le_i || q_o == $past(d_i)));

  // R5
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !le_q && clken_ni) |=> (le_i || q_o == $past(q_o)));
endmodule

// File: rtl/dual_path_bus_xcvr.sv
module dual_path_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH       = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  input  logic             ab_le_i,
  input  logic             ab_clken_ni,
  input  logic             ab_clk_i,
  input  logic             ab_oe_ni,
  input  logic             ba_le_i,
  input  logic             ba_clken_ni,
  input  logic             ba_clk_i,
  input  logic             ba_oe_ni,
  input  logic             clk_bus_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_out_en_o,
  output logic [WIDTH-1:0] b_pull_low_o,
  output logic             clk_fwd_pull_low_o,
  output logic             clk_ret_o,
  output logic             clk_ret_en_o
);
  localparam int unsigned NDIR = 2;
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;
  localparam logic [CB_BITS-1:0] CB_RST =
    (CB_BITS'(1) << CB_OE_N) | (CB_BITS'(1) << CB_CKEN_N);

  logic                 rst_sync_n;
  logic [WIDTH-1:0]     data_raw [NDIR];
  logic [WIDTH-1:0]     data_s   [NDIR];
  logic [CB_BITS-1:0]   ctrl_raw [NDIR];
  logic [CB_BITS-1:0]   ctrl_s   [NDIR];
  logic [WIDTH-1:0]     pres     [NDIR];
  logic [NDIR-1:0]      drive;
  logic                 clk_bus_s;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  always_comb begin
    data_raw[DIR_AB] = a_in_i;
    data_raw[DIR_BA] = b_in_i;
    ctrl_raw[DIR_AB] = '0;
    ctrl_raw[DIR_AB][CB_LE]     = ab_le_i;
    ctrl_raw[DIR_AB][CB_DCLK]   = ab_clk_i;
    ctrl_raw[DIR_AB][CB_CKEN_N] = ab_clken_ni;
    ctrl_raw[DIR_AB][CB_OE_N]   = ab_oe_ni;
    ctrl_raw[DIR_BA] = '0;
    ctrl_raw[DIR_BA][CB_LE]     = ba_le_i;
    ctrl_raw[DIR_BA][CB_DCLK]   = ba_clk_i;
    ctrl_raw[DIR_BA][CB_CKEN_N] = ba_clken_ni;
    ctrl_raw[DIR_BA][CB_OE_N]   = ba_oe_ni;
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .async_i (data_raw[d]),
      .sync_o  (data_s[d])
    );

    xcvr_sync #(.WIDTH(CB_BITS), .STAGES(SYNC_STAGES), .RST_VAL(CB_RST)) u_ctrl_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .async_i (ctrl_raw[d]),
      .sync_o  (ctrl_s[d])
    );

    xcvr_path #(.WIDTH(WIDTH)) u_path (
      .clk_i    (clk_i),
      .rst_ni   (rst_sync_n),
      .d_i      (data_s[d]),
      .le_i     (ctrl_s[d][CB_LE]),
      .clken_ni (ctrl_s[d][CB_CKEN_N]),
      .dclk_i   (ctrl_s[d][CB_DCLK]),
      .oe_ni    (ctrl_s[d][CB_OE_N]),
      .q_o      (pres[d]),
      .drive_o  (drive[d])
    );
  end

  xcvr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_bus_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (clk_bus_i),
    .sync_o  (clk_bus_s)
  );

  // Output shaping: three-state A side, wired-OR B side.
  assign a_out_o            = pres[DIR_BA];
  assign a_out_en_o         = drive[DIR_BA];
  assign b_pull_low_o       = {WIDTH{drive[DIR_AB]}} & ~pres[DIR_AB];
  assign clk_fwd_pull_low_o = drive[DIR_AB] & ~ctrl_s[DIR_AB][CB_DCLK];
  assign clk_ret_o          = drive[DIR_BA] & clk_bus_s;
  assign clk_ret_en_o       = drive[DIR_BA];

  // R7
  od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !drive[DIR_AB] |-> (b_pull_low_o == '0));

  // R9
  clk_fwd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (clk_fwd_pull_low_o || clk_ret_en_o) |-> !(ab_oe_ni && ba_oe_ni && $past(ab_oe_ni) &&
      $past(ba_oe_ni) && $past(ab_oe_ni, 2) && $past(ba_oe_ni, 2)));

  // R6
  a_release_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !a_out_en_o |-> !clk_ret_o);
endmodule

// File: tb/dual_path_bus_xcvr_tb.sv
module dual_path_bus_xcvr_tb_top;
  localparam int unsigned W = 17;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic ab_le, ab_clken_n, ab_clk, ab_oe_n;
  logic ba_le, ba_clken_n, ba_clk, ba_oe_n;
  logic clk_bus;
  logic [W-1:0] a_out, b_pl;
  logic a_en, clk_fwd_pl, clk_ret, clk_ret_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_path_bus_xcvr #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_in_i(a_in), .b_in_i(b_in),
    .ab_le_i(ab_le), .ab_clken_ni(ab_clken_n), .ab_clk_i(ab_clk), .ab_oe_ni(ab_oe_n),
    .ba_le_i(ba_le), .ba_clken_ni(ba_clken_n), .ba_clk_i(ba_clk), .ba_oe_ni(ba_oe_n),
    .clk_bus_i(clk_bus), .a_out_o(a_out), .a_out_en_o(a_en), .b_pull_low_o(b_pl),
    .clk_fwd_pull_low_o(clk_fwd_pl), .clk_ret_o(clk_ret), .clk_ret_en_o(clk_ret_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a_in = '0; b_in = '0; clk_bus = 1'b0;
    ab_le = 0; ab_clken_n = 0; ab_clk = 0; ab_oe_n = 1;
    ba_le = 0; ba_clken_n = 0; ba_clk = 0; ba_oe_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    a_in = 17'h1ABCD; b_in = 17'h05555;
    settle();
    check("R1 a_en", a_en, 0);
    check("R1 b_pl", b_pl, 0);
    check("R1 clk_fwd", clk_fwd_pl, 0);
    check("R1 clk_ret_en", clk_ret_en, 0);
    ab_oe_n = 0; ba_oe_n = 0;
    settle();
    check("R1 stored zero on B", b_pl, ALL1);
    check("R1 stored zero on A", a_out, 0);
    check("R1 a_en after oe", a_en, 1);
  endtask

  task automatic t_transparent();
    ab_le = 1; ab_clken_n = 1; a_in = 17'h0A5A5;
    settle();
    check("R2 follow", b_pl, ~17'h0A5A5 & ALL1);
    check("R7 mask", b_pl, ~17'h0A5A5 & ALL1);
    ab_clk = 1; a_in = 17'h12345;
    settle();
    check("R2 follow clk high", b_pl, ~17'h12345 & ALL1);
    ab_clken_n = 0; ab_clk = 0; a_in = 17'h15A5A;
    settle();
    check("R2 follow ce low", b_pl, ~17'h15A5A & ALL1);
  endtask

  task automatic t_latch();
    a_in = 17'h0F0F0;
    settle();
    ab_le = 0;
    settle();
    a_in = 17'h1FFFF;
    settle();
    check("R3 latched", b_pl, ~17'h0F0F0 & ALL1);
  endtask

  task automatic t_clocked();
    a_in = 17'h10001;
    settle();
    check("R4 before edge", b_pl, ~17'h0F0F0 & ALL1);
    ab_clk = 1;
    settle();
    check("R4 captured", b_pl, ~17'h10001 & ALL1);
    a_in = 17'h03C3C;
    settle();
    check("R4 steady high", b_pl, ~17'h10001 & ALL1);
    ab_clk = 0;
    settle();
    check("R4 falling edge", b_pl, ~17'h10001 & ALL1);
  endtask

  task automatic t_inhibit();
    ab_clken_n = 1; a_in = 17'h0AAAA;
    settle();
    ab_clk = 1;
    settle();
    ab_clk = 0;
    settle();
    check("R5 inhibit", b_pl, ~17'h10001 & ALL1);
  endtask

  task automatic t_latency();
    ab_clken_n = 0; a_in = 17'h00F00;
    settle();
    ab_clk = 1;
    @(posedge clk); #1;
    check("R10 not yet", b_pl, ~17'h10001 & ALL1);
    @(posedge clk); @(posedge clk); #1;
    check("R10 by third edge", b_pl, ~17'h00F00 & ALL1);
    @(negedge clk);
    ab_clk = 0;
    settle();
  endtask

  task automatic t_same_cycle();
    ab_le = 1; a_in = 17'h06666;
    settle();
    a_in = 17'h19999; ab_le = 0; ab_clk = 1;
    settle();
    check("R11 same cycle", b_pl, ~17'h19999 & ALL1);
    ab_clk = 0; a_in = 17'h00000;
    settle();
    check("R11 held", b_pl, ~17'h19999 & ALL1);
  endtask

  task automatic t_oe();
    ab_oe_n = 1; ba_oe_n = 1; clk_bus = 1;
    settle();
    check("R6 B released", b_pl, 0);
    check("R6 A released", a_en, 0);
    check("R9 fwd gated", clk_fwd_pl, 0);
    check("R9 ret gated", clk_ret, 0);
    ab_oe_n = 0;
    settle();
    check("R6 B redriven", b_pl, ~17'h19999 & ALL1);
  endtask

  task automatic t_ba();
    ba_oe_n = 0; ba_le = 1; b_in = 17'h13579;
    settle();
    check("R8 ba transparent", a_out, 17'h13579);
    ba_le = 0; ba_clken_n = 0; b_in = 17'h02468;
    settle();
    ba_clk = 1;
    settle();
    check("R8 ba clocked", a_out, 17'h13579 ^ 17'h13579 ^ 17'h02468);
    check("R8 ab untouched", b_pl, ~17'h19999 & ALL1);
    ba_clk = 0;
    settle();
  endtask

  task automatic t_clk_fwd();
    ab_clken_n = 1; ab_clk = 0; clk_bus = 1;
    settle();
    check("R9 fwd low", clk_fwd_pl, 1);
    check("R9 ret high", clk_ret, 1);
    check("R9 ret en", clk_ret_en, 1);
    ab_clk = 1; clk_bus = 0;
    settle();
    check("R9 fwd high", clk_fwd_pl, 0);
    check("R9 ret low", clk_ret, 0);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_latch();
    t_clocked();
    t_inhibit();
    t_latency();
    t_same_cycle();
    t_oe();
    t_ba();
    t_clk_fwd();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule